// File: doc/BRIEF.md
# Debug Command Execution Engine

This block carries out debug commands that arrive already decoded from a serial link. Each command has a 4-bit opcode, a 2-bit operand size, a 32-bit address and a 32-bit data word. The engine accepts one command at a time. It runs the command against a memory bus master port, a sixteen-entry register file port (eight data and eight address registers), a system-register port and a peripheral reset output. It then returns one response pulse that carries read data and a status code.

Two commands continue a block transfer. They keep no address of their own and work from an internal pointer. A memory read or write sets that pointer, and each continuation moves it forward. The peripheral reset command starts a fixed-length reset pulse that runs in the background, so further debug commands can be handled while it is active. Resume and patch-call end in a request pulse that carries the program counter where execution should restart. The processor pipeline sits outside this block.

Top module: `dbg_cmd_engine`

## Requirements
- R1: Opcode 1 (memory read) performs one bus read at `cmd_addr` with `bus_fc` = `sfc`. Size codes are 0 byte, 1 word and 2 long. The response data is the bus data zero-extended from the low 8, 16 or 32 bits.
- R2: Opcode 2 (memory write) performs one bus write of `cmd_data` at `cmd_addr` with `bus_fc` = `dfc` and `bus_size` = the command size. The response data is 0.
- R3: Opcode 3 (block read continuation) reads at the pointer. The pointer is the address of the previous memory read or continuation read plus that access's size in bytes (1, 2 or 4). The pointer then advances by the size of the current access.
- R4: Opcode 4 (block write continuation) writes `cmd_data` at the pointer, using the same pointer rules after a memory write or continuation write. The function code is `dfc`.
- R5: Opcode 11 holds `periph_rst` high for exactly 512 consecutive cycles. A second reset command while the pulse is active neither restarts nor lengthens it. Other commands keep executing while the pulse runs.
- R6: A block read continuation that does not follow a read, a block write continuation that does not follow a write, and any memory command with size code 3 all return status 1 (illegal) and make no bus access.
- R7: Opcode 6 writes `cmd_data` into the register selected by `cmd_addr[3:0]` (0-7 data, 8-15 address). Opcode 5 returns the value of that register.
- R8: Opcode 8 writes `cmd_data` to system register `cmd_addr[4:0]`. Opcode 7 returns that register when `sr_readable` is high. Otherwise opcode 7 returns status 2 (denied) with data 0.
- R9: Opcode 10 (patch call) does three things: it writes `pc_in` as a long word to address A7 (register 15) minus 4 with function code 5; it sets A7 to that address; it pulses `go_valid` once with `go_pc` = `cmd_addr`.
- R10: Opcode 9 (resume) pulses `go_valid` for one cycle with `go_pc` = `pc_in`. Opcode 0 does nothing and returns status 0 with data 0.
- R11: `cmd_ready` is high only when the engine is idle, and every accepted command produces exactly one single-cycle `rsp_valid`. A bus request holds its address until `bus_ack` arrives, however late that is.
- R12: Opcodes 12 to 15 return status 1 and have no other effect. Status 0 means done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_size | input | 2 | Operand size code |
| cmd_addr | input | 32 | Address or register selector |
| cmd_data | input | 32 | Operand data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 done, 1 illegal, 2 denied |
| rsp_data | output | 32 | Read result |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Write access |
| bus_size | output | 2 | Access size code |
| bus_fc | output | 3 | Address-space function code |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| sfc | input | 3 | Function code for reads |
| dfc | input | 3 | Function code for writes |
| reg_sel | output | 4 | Register file index |
| reg_we | output | 1 | Register file write strobe |
| reg_wdata | output | 32 | Register file write data |
| reg_rdata | input | 32 | Register file read data (combinational) |
| sr_sel | output | 5 | System register index |
| sr_we | output | 1 | System register write strobe |
| sr_wdata | output | 32 | System register write data |
| sr_rdata | input | 32 | System register read data |
| sr_readable | input | 1 | Selected system register is readable |
| pc_in | input | 32 | Current program counter |
| go_valid | output | 1 | Resume-execution request pulse |
| go_pc | output | 32 | Program counter to resume at |
| periph_rst | output | 1 | Peripheral reset pulse |

## Verification
The peripheral reset countdown and ordinary command execution can be active in the same cycle. The bench provokes this by issuing a reset command and then, while `periph_rst` is still high, a memory read and a second reset command. It judges the overlap by three things: the read must return the correct data, `periph_rst` must rise only once, and it must stay high for exactly 512 cycles in total.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SRW = 5,
  parameter int RST_CYCLES = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [3:0]     cmd_op,
  input  logic [1:0]     cmd_size,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_data,
  output logic           rsp_valid,
  output logic [1:0]     rsp_status,
  output logic [DW-1:0]  rsp_data,
  output logic           bus_req,
  output logic           bus_we,
  output logic [1:0]     bus_size,
  output logic [2:0]     bus_fc,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic           bus_ack,
  input  logic [DW-1:0]  bus_rdata,
  input  logic [2:0]     sfc,
  input  logic [2:0]     dfc,
  output logic [3:0]     reg_sel,
  output logic           reg_we,
  output logic [DW-1:0]  reg_wdata,
  input  logic [DW-1:0]  reg_rdata,
  output logic [SRW-1:0] sr_sel,
  output logic           sr_we,
  output logic [DW-1:0]  sr_wdata,
  input  logic [DW-1:0]  sr_rdata,
  input  logic           sr_readable,
  input  logic [AW-1:0]  pc_in,
  output logic           go_valid,
  output logic [AW-1:0]  go_pc,
  output logic           periph_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_MRD  = 4'd1;
  localparam logic [3:0] OP_MWR  = 4'd2;
  localparam logic [3:0] OP_DUMP = 4'd3;
  localparam logic [3:0] OP_FILL = 4'd4;
  localparam logic [3:0] OP_RREG = 4'd5;
  localparam logic [3:0] OP_WREG = 4'd6;
  localparam logic [3:0] OP_RSYS = 4'd7;
  localparam logic [3:0] OP_WSYS = 4'd8;
  localparam logic [3:0] OP_GO   = 4'd9;
  localparam logic [3:0] OP_CALL = 4'd10;
  localparam logic [3:0] OP_RST  = 4'd11;

  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_ILL = 2'd1;
  localparam logic [1:0] ST_DEN = 2'd2;

  localparam logic [1:0] BLK_NONE = 2'd0;
  localparam logic [1:0] BLK_RD   = 2'd1;
  localparam logic [1:0] BLK_WR   = 2'd2;

  localparam logic [2:0] FC_STACK = 3'd5;
  localparam logic [3:0] SP_IDX   = 4'd15;

  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_BUS, S_CFIN, S_GO} state_t;

  state_t        state, ex_next;
  logic [3:0]    q_op;
  logic [1:0]    q_size, q_bsize, blk;
  logic [AW-1:0] q_addr, q_baddr, ptr;
  logic [DW-1:0] q_data;
  logic          q_we;
  logic [2:0]    q_fc;
  logic [CW-1:0] rcnt;
  logic          ex_done;
  logic [1:0]    ex_st;
  logic [DW-1:0] ex_dat;
  logic          is_direct, is_wr;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic [1:0] s);
    case (s)
      2'd0:    fit = {{(DW-8){1'b0}}, d[7:0]};
      2'd1:    fit = {{(DW-16){1'b0}}, d[15:0]};
      default: fit = d;
    endcase
  endfunction

  assign cmd_ready = (state == S_IDLE);
  assign is_direct = (q_op == OP_MRD) || (q_op == OP_MWR);
  assign is_wr     = (q_op == OP_MWR) || (q_op == OP_FILL);

  assign bus_req   = (state == S_BUS);
  assign bus_we    = q_we;
  assign bus_addr  = q_baddr;
  assign bus_size  = q_bsize;
  assign bus_fc    = q_fc;
  assign bus_wdata = q_data;

  assign reg_sel   = (state == S_EXEC && (q_op == OP_RREG || q_op == OP_WREG)) ? q_addr[3:0] : SP_IDX;
  assign reg_we    = (state == S_EXEC && q_op == OP_WREG) || (state == S_CFIN);
  assign reg_wdata = (state == S_CFIN) ? DW'(q_baddr) : q_data;

  assign sr_sel    = q_addr[SRW-1:0];
  assign sr_we     = (state == S_EXEC) && (q_op == OP_WSYS);
  assign sr_wdata  = q_data;

  assign go_valid  = (state == S_GO);
  assign go_pc     = (q_op == OP_CALL) ? q_addr : pc_in;

  assign periph_rst = (rcnt != '0);

  always_comb begin
    ex_done = 1'b1;
    ex_st   = ST_OK;
    ex_dat  = '0;
    ex_next = S_IDLE;
    case (q_op)
      OP_NOP, OP_WREG, OP_WSYS, OP_RST: ;
      OP_MRD, OP_MWR, OP_DUMP, OP_FILL: begin
        if (q_size == 2'd3 || (q_op == OP_DUMP && blk != BLK_RD) ||
            (q_op == OP_FILL && blk != BLK_WR))
          ex_st = ST_ILL;
        else begin
          ex_done = 1'b0;
          ex_next = S_BUS;
        end
      end
      OP_RREG: ex_dat = reg_rdata;
      OP_RSYS: begin
        if (sr_readable) ex_dat = sr_rdata;
        else ex_st = ST_DEN;
      end
      OP_GO: begin
        ex_done = 1'b0;
        ex_next = S_GO;
      end
      OP_CALL: begin
        ex_done = 1'b0;
        ex_next = S_BUS;
      end
      default: ex_st = ST_ILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      q_op       <= OP_NOP;
      q_size     <= '0;
      q_addr     <= '0;
      q_data     <= '0;
      q_baddr    <= '0;
      q_bsize    <= '0;
      q_we       <= 1'b0;
      q_fc       <= '0;
      ptr        <= '0;
      blk        <= BLK_NONE;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          q_op   <= cmd_op;
          q_size <= cmd_size;
          q_addr <= cmd_addr;
          q_data <= cmd_data;
          state  <= S_EXEC;
        end
        S_EXEC: begin
          state <= ex_next;
          if (ex_done) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ex_st;
            rsp_data   <= ex_dat;
          end
          if (q_op == OP_CALL) begin
            q_baddr <= reg_rdata[AW-1:0] - AW'(4);
            q_we    <= 1'b1;
            q_fc    <= FC_STACK;
            q_bsize <= 2'd2;
            q_data  <= DW'(pc_in);
          end else begin
            q_baddr <= is_direct ? q_addr : ptr;
            q_we    <= is_wr;
            q_fc    <= is_wr ? dfc : sfc;
            q_bsize <= q_size;
          end
        end
        S_BUS: if (bus_ack) begin
          if (q_op == OP_CALL) state <= S_CFIN;
          else begin
            state      <= S_IDLE;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_data   <= q_we ? '0 : fit(bus_rdata, q_bsize);
            ptr        <= q_baddr + (AW'(1) << q_bsize);
            blk        <= q_we ? BLK_WR : BLK_RD;
          end
        end
        S_CFIN: state <= S_GO;
        S_GO: begin
          state      <= S_IDLE;
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_data   <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rcnt <= '0;
    else if (state == S_EXEC && q_op == OP_RST && rcnt == '0)
      rcnt <= CW'(RST_CYCLES);
    else if (rcnt != '0)
      rcnt <= rcnt - 1'b1;
  end
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk #(
  parameter int AW = 32,
  parameter int RST_CYCLES = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic          go_valid,
  input logic          periph_rst
);
  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= 0;
    else if (periph_rst) hi_len <= hi_len + 1;
    else hi_len <= 0;
  end

  p_rst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_rst) |-> hi_len == RST_CYCLES);

  p_rst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> hi_len < RST_CYCLES);

  p_go_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid |=> !go_valid);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_idle_nobus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_req);

  p_bus_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr));
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk #(.AW(AW), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
  .go_valid(go_valid), .periph_rst(periph_rst)
);

// File: tb/dbg_cmd_engine_bench.sv
module dbg_cmd_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_size = '0;
  logic [31:0] cmd_addr = '0, cmd_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_data;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [1:0]  bus_size;
  logic [2:0]  bus_fc;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [3:0]  reg_sel;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic [4:0]  sr_sel;
  logic        sr_we, sr_readable;
  logic [31:0] sr_wdata, sr_rdata;
  logic        go_valid, periph_rst;
  logic [31:0] go_pc;
  localparam logic [31:0] PC_NOW = 32'h0000_4A00;

  dbg_cmd_engine u_dbg_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_fc(bus_fc),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .sfc(3'd1), .dfc(3'd2),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sr_sel(sr_sel), .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .sr_readable(sr_readable), .pc_in(PC_NOW), .go_valid(go_valid), .go_pc(go_pc),
    .periph_rst(periph_rst)
  );

  logic [31:0] rf [16];
  logic [31:0] sr [32];
  assign reg_rdata   = rf[reg_sel];
  assign sr_rdata    = sr[sr_sel];
  assign sr_readable = (sr_sel < 5'd24);
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] <= (i == 15) ? 32'h0000_8000 : 32'h0100_0000 + i;
      for (int i = 0; i < 32; i++) sr[i] <= 32'h5000_0000 + i;
    end else begin
      if (reg_we) rf[reg_sel] <= reg_wdata;
      if (sr_we) sr[sr_sel] <= sr_wdata;
    end
  end

  int nbus = 0, wcnt = 0, ack_dly = 1;
  logic [31:0] lb_addr, lb_wdata;
  logic lb_we;
  logic [2:0] lb_fc;
  logic [1:0] lb_size;
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wcnt >= ack_dly) begin
        bus_ack = 1'b1;
        bus_rdata = {~bus_addr[15:0], bus_addr[15:0]};
        lb_addr = bus_addr; lb_wdata = bus_wdata; lb_we = bus_we;
        lb_fc = bus_fc; lb_size = bus_size;
        nbus++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  int ngo = 0, rst_hi = 0, rst_rise = 0;
  logic [31:0] last_go = '0;
  logic prev_rst = 1'b0;
  always @(negedge clk) begin
    if (go_valid) begin ngo++; last_go = go_pc; end
    if (periph_rst) rst_hi++;
    if (periph_rst && !prev_rst) rst_rise++;
    prev_rst = periph_rst;
  end

  int checks = 0, failures = 0, lat = 0;
  logic [1:0] r_st;
  logic [31:0] r_dat;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    int t;
    @(negedge clk);
    cmd_op = op; cmd_size = sz; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1; t = 0;
    while (!rsp_valid && t < 2000) begin @(negedge clk); lat++; t++; end
    r_st = rsp_status; r_dat = rsp_data;
  endtask

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  st;
    logic [31:0] rd;
    logic        bus;
    logic        we;
    logic [31:0] baddr;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  2'd0, 32'h0,    32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 32'h0,    8'd10}, // R10 nop
    '{4'd3,  2'd1, 32'h0,    32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd6},  // R6 dump unarmed
    '{4'd4,  2'd0, 32'h0,    32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd6},  // R6 fill unarmed
    '{4'd1,  2'd2, 32'h1000, 32'h0,        2'd0, 32'hEFFF1000, 1'b1, 1'b0, 32'h1000, 8'd1},  // R1
    '{4'd3,  2'd1, 32'h0,    32'h0,        2'd0, 32'h00001004, 1'b1, 1'b0, 32'h1004, 8'd3},  // R3
    '{4'd3,  2'd0, 32'h0,    32'h0,        2'd0, 32'h00000006, 1'b1, 1'b0, 32'h1006, 8'd3},  // R3
    '{4'd3,  2'd2, 32'h0,    32'h0,        2'd0, 32'hEFF81007, 1'b1, 1'b0, 32'h1007, 8'd3},  // R3
    '{4'd4,  2'd0, 32'h0,    32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd6},  // R6 fill after read
    '{4'd2,  2'd1, 32'h2000, 32'h1234,     2'd0, 32'h0,        1'b1, 1'b1, 32'h2000, 8'd2},  // R2
    '{4'd4,  2'd0, 32'h0,    32'hAB,       2'd0, 32'h0,        1'b1, 1'b1, 32'h2002, 8'd4},  // R4
    '{4'd4,  2'd2, 32'h0,    32'h11223344, 2'd0, 32'h0,        1'b1, 1'b1, 32'h2003, 8'd4},  // R4
    '{4'd3,  2'd0, 32'h0,    32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd6},  // R6 dump after write
    '{4'd1,  2'd3, 32'h3000, 32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd6},  // R6 size 3
    '{4'd1,  2'd0, 32'h12F5, 32'h0,        2'd0, 32'h000000F5, 1'b1, 1'b0, 32'h12F5, 8'd1},  // R1 byte
    '{4'd3,  2'd0, 32'h0,    32'h0,        2'd0, 32'h000000F6, 1'b1, 1'b0, 32'h12F6, 8'd3},  // R3 byte
    '{4'd6,  2'd0, 32'h3,    32'hDEAD0003, 2'd0, 32'h0,        1'b0, 1'b0, 32'h0,    8'd7},  // R7
    '{4'd5,  2'd0, 32'h3,    32'h0,        2'd0, 32'hDEAD0003, 1'b0, 1'b0, 32'h0,    8'd7},  // R7
    '{4'd5,  2'd0, 32'hA,    32'h0,        2'd0, 32'h0100000A, 1'b0, 1'b0, 32'h0,    8'd7},  // R7
    '{4'd6,  2'd0, 32'hC,    32'hA5A5000C, 2'd0, 32'h0,        1'b0, 1'b0, 32'h0,    8'd7},  // R7
    '{4'd5,  2'd0, 32'hC,    32'h0,        2'd0, 32'hA5A5000C, 1'b0, 1'b0, 32'h0,    8'd7},  // R7
    '{4'd8,  2'd0, 32'h2,    32'hCAFE0002, 2'd0, 32'h0,        1'b0, 1'b0, 32'h0,    8'd8},  // R8
    '{4'd7,  2'd0, 32'h2,    32'h0,        2'd0, 32'hCAFE0002, 1'b0, 1'b0, 32'h0,    8'd8},  // R8
    '{4'd7,  2'd0, 32'h19,   32'h0,        2'd2, 32'h0,        1'b0, 1'b0, 32'h0,    8'd8},  // R8 denied
    '{4'd15, 2'd0, 32'h0,    32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd12}, // R12
    '{4'd12, 2'd2, 32'h0,    32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 32'h0,    8'd12}  // R12
  };

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    int nb, ng, hi0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready && !rsp_valid && !bus_req && !go_valid, "R11 reset idle", {29'd0, cmd_ready, rsp_valid, bus_req}, 32'h4);
    chk(!periph_rst, "R5 reset state", {31'd0, periph_rst}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      nb = nbus;
      do_cmd(VEC[i].op, VEC[i].sz, VEC[i].addr, VEC[i].data);
      chk(r_st == VEC[i].st, $sformatf("R%0d vec%0d status", VEC[i].tag, i), {30'd0, r_st}, {30'd0, VEC[i].st});
      chk(r_dat == VEC[i].rd, $sformatf("R%0d vec%0d data", VEC[i].tag, i), r_dat, VEC[i].rd);
      chk((nbus - nb) == int'(VEC[i].bus), $sformatf("R%0d vec%0d bus count", VEC[i].tag, i), 32'(nbus - nb), {31'd0, VEC[i].bus});
      if (VEC[i].bus) begin
        chk(lb_addr == VEC[i].baddr, $sformatf("R%0d vec%0d addr", VEC[i].tag, i), lb_addr, VEC[i].baddr);
        chk(lb_we == VEC[i].we, $sformatf("R%0d vec%0d we", VEC[i].tag, i), {31'd0, lb_we}, {31'd0, VEC[i].we});
      end
    end

    // R1 read function code and size
    do_cmd(4'd1, 2'd1, 32'h0000_0040, 32'h0);
    chk(lb_fc == 3'd1 && lb_size == 2'd1, "R1 fc/size", {27'd0, lb_fc, lb_size}, {27'd0, 3'd1, 2'd1});
    // R2 write function code and data
    do_cmd(4'd2, 2'd2, 32'h0000_0080, 32'h7777_8888);
    chk(lb_fc == 3'd2 && lb_wdata == 32'h7777_8888, "R2 fc/wdata", lb_wdata, 32'h7777_8888);
    // R4 continuation write data and function code
    do_cmd(4'd4, 2'd0, 32'hFFFF_FFFF, 32'h0000_005A);
    chk(lb_addr == 32'h84 && lb_wdata == 32'h5A && lb_fc == 3'd2, "R4 fill data", lb_addr, 32'h84);

    // R11 long bus wait: engine busy and request held
    ack_dly = 30;
    fork
      do_cmd(4'd1, 2'd2, 32'h0000_0500, 32'h0);
      begin
        repeat (12) @(negedge clk);
        chk(!cmd_ready && bus_req && bus_addr == 32'h500, "R11 busy wait", {30'd0, cmd_ready, bus_req}, 32'h1);
      end
    join
    chk(lat > 30 && r_dat == 32'hFAFF0500, "R11 ack latency", r_dat, 32'hFAFF0500);
    ack_dly = 1;

    // R9 patch call
    ng = ngo;
    do_cmd(4'd10, 2'd0, 32'h0000_9100, 32'h0);
    chk(lb_addr == 32'h7FFC && lb_we && lb_wdata == PC_NOW && lb_fc == 3'd5 && lb_size == 2'd2,
        "R9 push", lb_addr, 32'h7FFC);
    chk(ngo == ng + 1 && last_go == 32'h9100, "R9 go target", last_go, 32'h9100);
    do_cmd(4'd5, 2'd0, 32'hF, 32'h0);
    chk(r_dat == 32'h7FFC, "R9 stack pointer", r_dat, 32'h7FFC);

    // R10 resume
    ng = ngo;
    do_cmd(4'd9, 2'd0, 32'h0000_1111, 32'h0);
    chk(ngo == ng + 1 && last_go == PC_NOW && r_st == 2'd0, "R10 resume", last_go, PC_NOW);

    // R5 reset pulse overlapping other commands and a retrigger attempt
    hi0 = rst_hi;
    do_cmd(4'd11, 2'd0, 32'h0, 32'h0);
    chk(periph_rst && r_st == 2'd0, "R5 reset rises", {31'd0, periph_rst}, 32'd1);
    repeat (50) @(negedge clk);
    do_cmd(4'd1, 2'd2, 32'h0000_0600, 32'h0);
    chk(periph_rst && r_dat == 32'hF9FF0600, "R5 read during reset", r_dat, 32'hF9FF0600);
    repeat (100) @(negedge clk);
    do_cmd(4'd11, 2'd0, 32'h0, 32'h0);
    repeat (600) @(negedge clk);
    chk(rst_hi - hi0 == 512, "R5 reset length", 32'(rst_hi - hi0), 32'd512);
    chk(rst_rise == 1, "R5 single rise", 32'(rst_rise), 32'd1);

    summary();
    $finish;
  end
endmodule